// File: doc/BRIEF.md
# SPI Interrupt Flag Generator

This block sits beside an SPI shift engine and turns its per-character events and FIFO fill levels into sticky status flags and two registered interrupt lines. One line carries receive and general events. The other line serves the transmit side. In single-buffer mode the block keeps the last received word in a holding register. It raises a completion flag for every character and flags an overrun when a character arrives before software has read the previous one. In FIFO mode the flags follow threshold comparisons against the FIFO fill counts. The receive flag compares at or above its level. The transmit flag compares at or below its level.

The completion strobe, the read strobe and the clear strobes are single-cycle pulses. They carry no back-pressure: a finished character cannot be held back by the shifter, so a character that lands on an unread one is recorded as an overrun rather than stalled. Fill counts, thresholds and enables are plain level inputs. Software clears each flag with its own strobe.

Top module: `spi_irq_unit`

## Requirements
- R1: In single-buffer mode (`fifo_mode`=0), a `char_done` pulse loads `rx_word` into `rx_hold` and sets `done_flag`, both visible after that same clock edge. `rx_hold` also loads on `char_done` in FIFO mode.
- R2: `done_flag` drives `irq_rx` only while `done_ie` is 1.
- R3: `ovr_flag` sets when `char_done` arrives while the previous character is still unread. A character is unread if it was loaded by an earlier `char_done` and no `rx_read` has occurred since. A `rx_read` in the same cycle as the new `char_done` counts as a read.
- R4: An overrun raises `irq_rx` only if `ovr_ie` is 1 at that moment and `ovr_flag` was clear just before it. Further overruns while `ovr_flag` stays set raise nothing new. `ovr_clr` clears the flag and its request and re-arms the interrupt.
- R5: In FIFO mode, `rxff_flag` sets in any cycle where `rx_fill >= rx_level` (both unsigned, 0 to 16). It drives `irq_rx` only while `rxff_ie` is 1.
- R6: In FIFO mode, `txff_flag` sets in any cycle where `tx_fill <= tx_level`. It drives `irq_tx` only while `txff_ie` is 1.
- R7: In single-buffer mode, `irq_tx` stays 0 and the two FIFO flags never set. In FIFO mode, `done_flag` and `ovr_flag` never set.
- R8: Every flag is sticky until its own clear strobe (`done_clr`, `ovr_clr`, `rxff_clr`, `txff_clr`). When a set condition and the clear strobe fall in the same cycle, the flag stays set.
- R9: In the cycle after `fifo_mode` changes value, all four flags and the overrun request are 0.
- R10: While `rst_n` is 0 at a clock edge, both interrupt lines, all flags and `rx_hold` become 0.
- R11: Both interrupt lines are registered levels. Each reflects its flag and enable after the same edge at which the flag itself becomes visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_mode | input | 1 | 0 = single-buffer mode, 1 = FIFO mode |
| char_done | input | 1 | Pulse: a character finished shifting |
| rx_word | input | DATA_W | Received character, valid with `char_done` |
| rx_read | input | 1 | Pulse: software read the holding register |
| rx_fill | input | CNT_W | Receive FIFO fill count |
| rx_level | input | CNT_W | Receive interrupt threshold |
| tx_fill | input | CNT_W | Transmit FIFO fill count |
| tx_level | input | CNT_W | Transmit interrupt threshold |
| done_ie | input | 1 | Completion interrupt enable |
| ovr_ie | input | 1 | Overrun interrupt enable |
| rxff_ie | input | 1 | Receive FIFO interrupt enable |
| txff_ie | input | 1 | Transmit FIFO interrupt enable |
| done_clr | input | 1 | Pulse: clear completion flag |
| ovr_clr | input | 1 | Pulse: clear overrun flag and re-arm |
| rxff_clr | input | 1 | Pulse: clear receive FIFO flag |
| txff_clr | input | 1 | Pulse: clear transmit FIFO flag |
| irq_rx | output | 1 | Combined receive/general interrupt line |
| irq_tx | output | 1 | Transmit interrupt line |
| rx_hold | output | DATA_W | Received-word holding register |
| done_flag | output | 1 | Completion flag |
| ovr_flag | output | 1 | Overrun flag |
| rxff_flag | output | 1 | Receive FIFO threshold flag |
| txff_flag | output | 1 | Transmit FIFO threshold flag |

## Verification
The threshold logic is driven with fill/level pairs just below, at and just above each level, and with the extremes 0 and 16. These pairs separate `>=` from `>` and `<=` from `<`, and show that the two comparisons run in opposite directions. The single-buffer path is driven with character streams that are read, left unread, and read in the same cycle as the next character. This shows that overrun follows unread status. A second overrun with the enable turned on later separates a fresh-flag event from a level-sensitive one. Clears that coincide with set conditions, and toggles of the mode select, expose the priority between set, clear and mode flush.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_FIFO   = 1'b1
  } irq_mode_e;

  // threshold comparison direction chosen per FIFO side
  typedef enum logic {
    CMP_AT_OR_ABOVE = 1'b0,
    CMP_AT_OR_BELOW = 1'b1
  } cmp_dir_e;

  function automatic logic level_hit(input cmp_dir_e dir, input logic [7:0] fill,
                                     input logic [7:0] level);
    return (dir == CMP_AT_OR_ABOVE) ? (fill >= level) : (fill <= level);
  endfunction
endpackage

// File: rtl/spi_irq_sticky.sv
module spi_irq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic kill,
  output logic q,
  output logic q_nxt
);
  always_comb begin
    if (kill)     q_nxt = 1'b0;
    else if (set) q_nxt = 1'b1;
    else if (clr) q_nxt = 1'b0;
    else          q_nxt = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set && !kill |=> q);
  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q && !clr && !kill |=> q);
endmodule

// File: rtl/spi_irq_single.sv
module spi_irq_single #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              kill,
  input  logic              char_done,
  input  logic [DATA_W-1:0] rx_word,
  input  logic              rx_read,
  input  logic              done_clr,
  input  logic              ovr_clr,
  input  logic              ovr_ie,
  output logic [DATA_W-1:0] rx_hold,
  output logic              done_q,
  output logic              done_nxt,
  output logic              ovr_q,
  output logic              ovr_req_q,
  output logic              ovr_req_nxt
);
  logic unread;
  logic ovr_nxt;
  logic done_set, ovr_set;

  assign done_set = en && char_done;
  assign ovr_set  = en && char_done && unread && !rx_read;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_hold <= '0;
      unread  <= 1'b0;
    end else begin
      if (char_done) rx_hold <= rx_word;
      if (kill)           unread <= 1'b0;
      else if (char_done) unread <= 1'b1;
      else if (rx_read)   unread <= 1'b0;
    end
  end

  spi_irq_sticky u_done (
    .clk(clk), .rst_n(rst_n), .set(done_set), .clr(done_clr), .kill(kill),
    .q(done_q), .q_nxt(done_nxt)
  );

  spi_irq_sticky u_ovr (
    .clk(clk), .rst_n(rst_n), .set(ovr_set), .clr(ovr_clr), .kill(kill),
    .q(ovr_q), .q_nxt(ovr_nxt)
  );

  // request latches only on a fresh flag with the enable present
  always_comb begin
    if (kill)                            ovr_req_nxt = 1'b0;
    else if (ovr_set && !ovr_q && ovr_ie) ovr_req_nxt = 1'b1;
    else if (ovr_clr)                    ovr_req_nxt = 1'b0;
    else                                 ovr_req_nxt = ovr_req_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ovr_req_q <= 1'b0;
    else        ovr_req_q <= ovr_req_nxt;
  end

  // R1
  hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |=> rx_hold == $past(rx_word));
  // R3
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(unread) && $past(char_done));
  // R4
  ovr_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q && !ovr_clr |=> !$rose(ovr_req_q));
endmodule

// File: rtl/spi_irq_fifo.sv
module spi_irq_fifo
  import spi_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             kill,
  input  logic [CNT_W-1:0] rx_fill,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [CNT_W-1:0] tx_fill,
  input  logic [CNT_W-1:0] tx_level,
  input  logic             rxff_clr,
  input  logic             txff_clr,
  output logic             rxff_q,
  output logic             rxff_nxt,
  output logic             txff_q,
  output logic             txff_nxt
);
  localparam int SIDES = 2;
  localparam int CMP_W = 8;

  logic [CNT_W-1:0] fill  [SIDES];
  logic [CNT_W-1:0] level [SIDES];
  logic [SIDES-1:0] clr, hit, q, nxt;

  assign fill[0]  = rx_fill;
  assign level[0] = rx_level;
  assign fill[1]  = tx_fill;
  assign level[1] = tx_level;
  assign clr      = {txff_clr, rxff_clr};

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    localparam cmp_dir_e DIR = (s == 0) ? CMP_AT_OR_ABOVE : CMP_AT_OR_BELOW;
    assign hit[s] = en && level_hit(DIR, CMP_W'(fill[s]), CMP_W'(level[s]));
    spi_irq_sticky u_flag (
      .clk(clk), .rst_n(rst_n), .set(hit[s]), .clr(clr[s]), .kill(kill),
      .q(q[s]), .q_nxt(nxt[s])
    );
  end

  assign rxff_q   = q[0];
  assign rxff_nxt = nxt[0];
  assign txff_q   = q[1];
  assign txff_nxt = nxt[1];

  // R5
  rx_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && !kill && (rx_fill >= rx_level) |=> rxff_q);
  // R6
  tx_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && !kill && (tx_fill <= tx_level) |=> txff_q);
  // R7
  fifo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !rxff_q && !txff_q |=> !rxff_q && !txff_q);
endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
  import spi_irq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_mode,
  input  logic              char_done,
  input  logic [DATA_W-1:0] rx_word,
  input  logic              rx_read,
  input  logic [CNT_W-1:0]  rx_fill,
  input  logic [CNT_W-1:0]  rx_level,
  input  logic [CNT_W-1:0]  tx_fill,
  input  logic [CNT_W-1:0]  tx_level,
  input  logic              done_ie,
  input  logic              ovr_ie,
  input  logic              rxff_ie,
  input  logic              txff_ie,
  input  logic              done_clr,
  input  logic              ovr_clr,
  input  logic              rxff_clr,
  input  logic              txff_clr,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic [DATA_W-1:0] rx_hold,
  output logic              done_flag,
  output logic              ovr_flag,
  output logic              rxff_flag,
  output logic              txff_flag
);
  irq_mode_e mode, mode_q;
  logic kill;
  logic done_nxt, ovr_req_q, ovr_req_nxt, rxff_nxt, txff_nxt;

  assign mode = irq_mode_e'(fifo_mode);
  assign kill = (mode != mode_q);

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_SINGLE;
    else        mode_q <= mode;
  end

  spi_irq_single #(.DATA_W(DATA_W)) u_single (
    .clk(clk), .rst_n(rst_n), .en(mode == MODE_SINGLE), .kill(kill),
    .char_done(char_done), .rx_word(rx_word), .rx_read(rx_read),
    .done_clr(done_clr), .ovr_clr(ovr_clr), .ovr_ie(ovr_ie),
    .rx_hold(rx_hold), .done_q(done_flag), .done_nxt(done_nxt),
    .ovr_q(ovr_flag), .ovr_req_q(ovr_req_q), .ovr_req_nxt(ovr_req_nxt)
  );

  spi_irq_fifo #(.CNT_W(CNT_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .en(mode == MODE_FIFO), .kill(kill),
    .rx_fill(rx_fill), .rx_level(rx_level), .tx_fill(tx_fill), .tx_level(tx_level),
    .rxff_clr(rxff_clr), .txff_clr(txff_clr),
    .rxff_q(rxff_flag), .rxff_nxt(rxff_nxt), .txff_q(txff_flag), .txff_nxt(txff_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_rx <= 1'b0;
      irq_tx <= 1'b0;
    end else if (mode == MODE_FIFO) begin
      irq_rx <= rxff_nxt && rxff_ie;
      irq_tx <= txff_nxt && txff_ie;
    end else begin
      irq_rx <= (done_nxt && done_ie) || ovr_req_nxt;
      irq_tx <= 1'b0;
    end
  end

  // R7
  no_tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |=> !irq_tx);
  // R9
  mode_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !done_flag && !ovr_flag && !rxff_flag && !txff_flag && !ovr_req_q);
  // R2
  done_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode && !done_ie && !ovr_req_nxt |=> !irq_rx);
  // R5
  rx_fifo_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_mode && !rxff_ie |=> !irq_rx);
endmodule

// File: tb/sim_spi_irq_unit.sv
module sim_spi_irq_unit;
  localparam int DW = 16;
  localparam int CW = 5;
  localparam int NV = 8;
  // {rx_fill, rx_level, tx_fill, tx_level, exp_rx, exp_tx}
  localparam logic [21:0] VEC [NV] = '{
    {5'd3,  5'd4,  5'd3,  5'd4,  1'b0, 1'b1},
    {5'd4,  5'd4,  5'd4,  5'd4,  1'b1, 1'b1},
    {5'd5,  5'd4,  5'd5,  5'd4,  1'b1, 1'b0},
    {5'd0,  5'd0,  5'd16, 5'd16, 1'b1, 1'b1},
    {5'd16, 5'd16, 5'd0,  5'd0,  1'b1, 1'b1},
    {5'd15, 5'd16, 5'd1,  5'd0,  1'b0, 1'b0},
    {5'd0,  5'd1,  5'd16, 5'd15, 1'b0, 1'b0},
    {5'd8,  5'd2,  5'd9,  5'd10, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n, fifo_mode, char_done, rx_read;
  logic [DW-1:0] rx_word;
  logic [CW-1:0] rx_fill, rx_level, tx_fill, tx_level;
  logic done_ie, ovr_ie, rxff_ie, txff_ie;
  logic done_clr, ovr_clr, rxff_clr, txff_clr;
  logic irq_rx, irq_tx, done_flag, ovr_flag, rxff_flag, txff_flag;
  logic [DW-1:0] rx_hold;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  spi_irq_unit #(.DATA_W(DW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .char_done(char_done),
    .rx_word(rx_word), .rx_read(rx_read), .rx_fill(rx_fill), .rx_level(rx_level),
    .tx_fill(tx_fill), .tx_level(tx_level), .done_ie(done_ie), .ovr_ie(ovr_ie),
    .rxff_ie(rxff_ie), .txff_ie(txff_ie), .done_clr(done_clr), .ovr_clr(ovr_clr),
    .rxff_clr(rxff_clr), .txff_clr(txff_clr), .irq_rx(irq_rx), .irq_tx(irq_tx),
    .rx_hold(rx_hold), .done_flag(done_flag), .ovr_flag(ovr_flag),
    .rxff_flag(rxff_flag), .txff_flag(txff_flag)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    char_done = 1'b0; rx_read = 1'b0;
    done_clr = 1'b0; ovr_clr = 1'b0; rxff_clr = 1'b0; txff_clr = 1'b0;
  endtask

  task automatic fifo_quiet();
    rx_fill = 5'd0; rx_level = 5'd16; tx_fill = 5'd16; tx_level = 5'd0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; fifo_mode = 1'b0; char_done = 1'b0; rx_read = 1'b0; rx_word = '0;
    done_ie = 1'b0; ovr_ie = 1'b0; rxff_ie = 1'b0; txff_ie = 1'b0;
    done_clr = 1'b0; ovr_clr = 1'b0; rxff_clr = 1'b0; txff_clr = 1'b0;
    fifo_quiet();
    repeat (3) tick();
    chk("R10", "irq_rx in reset", irq_rx, 0);
    chk("R10", "irq_tx in reset", irq_tx, 0);
    chk("R10", "flags in reset", {done_flag, ovr_flag, rxff_flag, txff_flag}, 0);
    chk("R10", "rx_hold in reset", rx_hold, 0);
    rst_n = 1'b1;

    // single-buffer mode with FIFO conditions true: must stay inert (R7)
    rx_fill = 5'd5; rx_level = 5'd1; tx_fill = 5'd0; tx_level = 5'd5;
    rxff_ie = 1'b1; txff_ie = 1'b1; done_ie = 1'b1;
    char_done = 1'b1; rx_word = 16'hA5A5;
    tick();
    chk("R1", "rx_hold load", rx_hold, 16'hA5A5);
    chk("R1", "done_flag set", done_flag, 1);
    chk("R11", "irq_rx with done same edge", irq_rx, 1);
    chk("R7", "irq_tx in single mode", irq_tx, 0);
    chk("R7", "fifo flags in single mode", {rxff_flag, txff_flag}, 0);
    fifo_quiet();

    rx_read = 1'b1; done_clr = 1'b1;
    tick();
    chk("R8", "done cleared", done_flag, 0);
    chk("R2", "irq_rx after clear", irq_rx, 0);

    done_ie = 1'b0; char_done = 1'b1; rx_word = 16'h3C3C;
    tick();
    chk("R2", "done flag without enable", done_flag, 1);
    chk("R2", "irq_rx gated by done_ie", irq_rx, 0);
    chk("R3", "no overrun after read", ovr_flag, 0);

    char_done = 1'b1; rx_word = 16'h5A5A;
    tick();
    chk("R3", "overrun on unread", ovr_flag, 1);
    chk("R4", "no irq with ovr_ie=0", irq_rx, 0);

    ovr_ie = 1'b1; char_done = 1'b1; rx_word = 16'h1111;
    tick();
    chk("R4", "repeat overrun no new event", irq_rx, 0);
    chk("R1", "rx_hold follows newest", rx_hold, 16'h1111);

    ovr_clr = 1'b1; rx_read = 1'b1; done_clr = 1'b1;
    tick();
    chk("R4", "ovr_clr clears flag", ovr_flag, 0);

    char_done = 1'b1; rx_word = 16'h2222;
    tick();
    chk("R3", "first char no overrun", ovr_flag, 0);

    char_done = 1'b1; rx_word = 16'h3333; rx_read = 1'b1;
    tick();
    chk("R3", "read in same cycle avoids overrun", ovr_flag, 0);

    char_done = 1'b1; rx_word = 16'h4444;
    tick();
    chk("R4", "rearmed overrun flag", ovr_flag, 1);
    chk("R4", "rearmed overrun irq", irq_rx, 1);

    tick();
    chk("R8", "overrun sticky", ovr_flag, 1);
    chk("R4", "overrun irq level held", irq_rx, 1);

    char_done = 1'b1; rx_word = 16'h5555; done_clr = 1'b1;
    tick();
    chk("R8", "set wins over clear", done_flag, 1);

    ovr_clr = 1'b1; done_clr = 1'b1; rx_read = 1'b1;
    tick();
    chk("R8", "all single flags cleared", {done_flag, ovr_flag}, 0);
    chk("R4", "irq_rx after ovr_clr", irq_rx, 0);

    char_done = 1'b1; rx_word = 16'h6666;
    tick();
    chk("R1", "done before mode change", done_flag, 1);
    fifo_mode = 1'b1;
    tick();
    chk("R9", "mode change flush", {done_flag, ovr_flag, rxff_flag, txff_flag}, 0);

    // FIFO threshold table (R5, R6)
    for (int i = 0; i < NV; i++) begin
      fifo_quiet(); rxff_clr = 1'b1; txff_clr = 1'b1;
      tick();
      {rx_fill, rx_level, tx_fill, tx_level} = VEC[i][21:2];
      tick();
      chk("R5", $sformatf("vec %0d rxff_flag", i), rxff_flag, VEC[i][1]);
      chk("R5", $sformatf("vec %0d irq_rx", i), irq_rx, VEC[i][1]);
      chk("R6", $sformatf("vec %0d txff_flag", i), txff_flag, VEC[i][0]);
      chk("R6", $sformatf("vec %0d irq_tx", i), irq_tx, VEC[i][0]);
    end

    fifo_quiet(); rxff_clr = 1'b1; txff_clr = 1'b1;
    char_done = 1'b1; rx_word = 16'h7777;
    tick();
    chk("R7", "no done flag in FIFO mode", {done_flag, ovr_flag}, 0);
    chk("R1", "rx_hold loads in FIFO mode", rx_hold, 16'h7777);
    chk("R8", "fifo flags cleared", {rxff_flag, txff_flag}, 0);

    rxff_ie = 1'b0; txff_ie = 1'b0;
    rx_fill = 5'd9; rx_level = 5'd9; tx_fill = 5'd2; tx_level = 5'd2;
    tick();
    chk("R5", "rx flag without enable", rxff_flag, 1);
    chk("R5", "irq_rx gated by rxff_ie", irq_rx, 0);
    chk("R6", "irq_tx gated by txff_ie", irq_tx, 0);

    rxff_ie = 1'b1; txff_ie = 1'b1; rxff_clr = 1'b1; txff_clr = 1'b1;
    tick();
    chk("R8", "fifo set wins over clear", {rxff_flag, txff_flag}, 2'b11);
    chk("R11", "irqs follow enables", {irq_rx, irq_tx}, 2'b11);

    fifo_quiet();
    tick();
    chk("R8", "fifo flags sticky", {rxff_flag, txff_flag}, 2'b11);

    fifo_mode = 1'b0;
    tick();
    chk("R9", "flush on return to single", {rxff_flag, txff_flag}, 0);
    chk("R7", "irq_tx low after return", irq_tx, 0);

    finish_run();
  end
endmodule